// File: doc/BRIEF.md
# Scalar Float Compare Mask Unit

The unit compares the low single-precision lanes of two 128-bit operands and turns the outcome into a lane-wide mask. The low three bits of an 8-bit immediate pick one of eight relations. These are equal, less-than, less-or-equal, unordered, their negations, and ordered. The first operand's lane always sits on the left of the relation. When the relation holds, the low 32 bits of the result are all ones; otherwise they are all zeros. The upper 96 bits pass through unchanged from the first operand.

NaN detection, signed zeros and denormals follow IEEE-754 single-precision ordering. An invalid-operation flag reports signaling NaNs, and quiet NaNs seen by the ordering relations. Immediates above 7 are reserved: they raise a flag and produce an all-zero low lane. The output is registered with one cycle of latency and is qualified by a valid strobe.

Greater-than relations have no code of their own. A caller obtains them by swapping the operands and using less-than or less-or-equal.

Top module: `sfc_mask_unit`

## Requirements
- R1: imm_i[2:0] selects the relation: 0 eq, 1 lt, 2 le, 3 unordered, 4 not-eq, 5 not-lt, 6 not-le, 7 ordered.
- R2: The relation is evaluated as A op B, with A = op_a_i[31:0] and B = op_b_i[31:0]. Swapping the operands with code 1 or 2 yields greater-than or greater-or-equal.
- R3: result_o[31:0] is 0xFFFFFFFF when the relation holds and 0x00000000 when it does not.
- R4: result_o[127:32] equals op_a_i[127:32] of the accepted input.
- R5: If any of imm_i[7:3] is set, rsvd_o is 1, result_o[31:0] is zero and invalid_o is 0. Otherwise rsvd_o is 0.
- R6: A value is NaN when its exponent is all ones and its mantissa is non-zero. If either lane is NaN, codes 0, 1, 2 and 7 are false and codes 3, 4, 5 and 6 are true.
- R7: +0 and -0 compare equal. Denormals are compared exactly, without flushing.
- R8: Non-NaN values are ordered by sign-magnitude, and the magnitude order is reversed when both are negative.
- R9: For a non-reserved code, invalid_o is 1 when either lane is a signaling NaN (mantissa MSB clear). It is also 1 when a quiet NaN is present and the code is 1, 2, 5 or 6. Otherwise it is 0.
- R10: Outputs update one clock after valid_i. valid_o equals valid_i delayed by one clock. Reset clears every output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Input qualifier |
| op_a_i | input | 128 | First operand, left side of the relation |
| op_b_i | input | 128 | Second operand, right side of the relation |
| imm_i | input | 8 | Predicate immediate |
| result_o | output | 128 | Mask lane plus pass-through upper lanes |
| valid_o | output | 1 | Result qualifier |
| rsvd_o | output | 1 | Reserved predicate seen |
| invalid_o | output | 1 | Invalid-operation flag |

## Verification
The bench feeds pairs of signed zeros. A unit that compared raw bits would report them unequal and would order -0 below +0. It feeds pairs of negatives, which catch a magnitude compare that was never reversed. It mixes quiet and signaling NaNs under every code, so a swapped true/false table for unordered pairs shows up, and so does an invalid flag raised for the equality codes. It also drives immediates with high bits set, which catch a decoder that reads only the low three bits. It runs greater-than by operand swap, and it checks that denormal neighbours stay distinct, which catches any flushing of denormals to zero.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  typedef enum logic [2:0] {
    PRED_EQ    = 3'd0,
    PRED_LT    = 3'd1,
    PRED_LE    = 3'd2,
    PRED_UNORD = 3'd3,
    PRED_NEQ   = 3'd4,
    PRED_NLT   = 3'd5,
    PRED_NLE   = 3'd6,
    PRED_ORD   = 3'd7
  } pred_e;

  typedef struct packed {
    logic sign;
    logic zero;
    logic nan;
    logic snan;
  } fclass_t;
endpackage

// File: rtl/sfc_classify.sv
module sfc_classify
  import sfc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] val_i,
  output fclass_t              cls_o
);
  localparam int LANE_W = EXP_W + MAN_W + 1;

  logic [EXP_W-1:0] exp_w;
  logic [MAN_W-1:0] man_w;

  assign exp_w = val_i[LANE_W-2 -: EXP_W];
  assign man_w = val_i[MAN_W-1:0];

  always_comb begin
    cls_o.sign = val_i[LANE_W-1];
    cls_o.zero = (exp_w == '0) && (man_w == '0);
    cls_o.nan  = (exp_w == '1) && (man_w != '0);
    cls_o.snan = cls_o.nan && !man_w[MAN_W-1];
  end
endmodule

// File: rtl/sfc_relate.sv
module sfc_relate
  import sfc_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  input  fclass_t              cls_a_i,
  input  fclass_t              cls_b_i,
  output logic                 eq_o,
  output logic                 lt_o,
  output logic                 unord_o
);
  localparam int MAG_W = EXP_W + MAN_W;

  logic [MAG_W-1:0] mag_a, mag_b;
  logic             mag_lt, mag_gt, both_zero;

  assign mag_a     = a_i[MAG_W-1:0];
  assign mag_b     = b_i[MAG_W-1:0];
  assign mag_lt    = mag_a < mag_b;
  assign mag_gt    = mag_a > mag_b;
  assign both_zero = cls_a_i.zero && cls_b_i.zero;

  always_comb begin
    unord_o = cls_a_i.nan || cls_b_i.nan;
    eq_o    = 1'b0;
    lt_o    = 1'b0;
    if (!unord_o) begin
      eq_o = both_zero || (a_i == b_i);
      if (both_zero)                     lt_o = 1'b0;
      else if (cls_a_i.sign != cls_b_i.sign) lt_o = cls_a_i.sign;
      else if (cls_a_i.sign)             lt_o = mag_gt; // both negative: reversed
      else                               lt_o = mag_lt;
    end
  end

  always_comb begin
    AST_EQ_LT_EXCL: assert (!(eq_o && lt_o));                  // R8
    AST_UNORD_FALSE: assert (!(unord_o && (eq_o || lt_o)));   // R6
  end
endmodule

// File: rtl/sfc_mask_unit.sv
module sfc_mask_unit
  import sfc_pkg::*;
#(
  parameter int DATA_W = 128,
  parameter int EXP_W  = 8,
  parameter int MAN_W  = 23,
  parameter int IMM_W  = 8,
  parameter int PRED_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] op_a_i,
  input  logic [DATA_W-1:0] op_b_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              rsvd_o,
  output logic              invalid_o
);
  localparam int LANE_W = EXP_W + MAN_W + 1;

  logic [LANE_W-1:0] lane_w [2];
  fclass_t           cls_w  [2];

  assign lane_w[0] = op_a_i[LANE_W-1:0];
  assign lane_w[1] = op_b_i[LANE_W-1:0];

  for (genvar g = 0; g < 2; g++) begin : g_cls
    sfc_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val_i (lane_w[g]),
      .cls_o (cls_w[g])
    );
  end

  logic eq_w, lt_w, unord_w;

  sfc_relate #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rel (
    .a_i     (lane_w[0]),
    .b_i     (lane_w[1]),
    .cls_a_i (cls_w[0]),
    .cls_b_i (cls_w[1]),
    .eq_o    (eq_w),
    .lt_o    (lt_w),
    .unord_o (unord_w)
  );

  pred_e pred_w;
  logic  rsvd_w, hit_w, ord_pred_w, inv_w;

  assign pred_w = pred_e'(imm_i[PRED_W-1:0]);
  assign rsvd_w = imm_i[IMM_W-1:PRED_W] != '0;

  always_comb begin
    unique case (pred_w)
      PRED_EQ:    hit_w = eq_w;
      PRED_LT:    hit_w = lt_w;
      PRED_LE:    hit_w = lt_w || eq_w;
      PRED_UNORD: hit_w = unord_w;
      PRED_NEQ:   hit_w = !eq_w;
      PRED_NLT:   hit_w = !lt_w;
      PRED_NLE:   hit_w = !(lt_w || eq_w);
      PRED_ORD:   hit_w = !unord_w;
      default:    hit_w = 1'b0;
    endcase
    ord_pred_w = (pred_w == PRED_LT) || (pred_w == PRED_LE) ||
                 (pred_w == PRED_NLT) || (pred_w == PRED_NLE);
    inv_w = !rsvd_w && (cls_w[0].snan || cls_w[1].snan || (unord_w && ord_pred_w));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o  <= '0;
      valid_o   <= 1'b0;
      rsvd_o    <= 1'b0;
      invalid_o <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o[DATA_W-1:LANE_W] <= op_a_i[DATA_W-1:LANE_W];
        result_o[LANE_W-1:0]      <= {LANE_W{hit_w && !rsvd_w}};
        rsvd_o                    <= rsvd_w;
        invalid_o                 <= inv_w;
      end
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);                                              // R10
  AST_VALID_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);                                            // R10
  AST_UPPER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> result_o[DATA_W-1:LANE_W] == $past(op_a_i[DATA_W-1:LANE_W])); // R4
  AST_MASK_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (result_o[LANE_W-1:0] == '0 || result_o[LANE_W-1:0] == '1)); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && imm_i[IMM_W-1:PRED_W] != '0) |=>
      (rsvd_o && !invalid_o && result_o[LANE_W-1:0] == '0));          // R5
  AST_SNAN_INV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !rsvd_w && (cls_w[0].snan || cls_w[1].snan)) |=> invalid_o); // R9
endmodule

// File: tb/tb_sfc_mask_unit.sv
module tb_sfc_mask_unit;
  typedef struct {
    logic [127:0] res;
    logic         rsvd;
    logic         inv;
    string        tag;
  } exp_t;

  logic         clk = 0, rst_ni = 0, valid_i = 0;
  logic [127:0] op_a_i = '0, op_b_i = '0;
  logic [7:0]   imm_i = '0;
  logic [127:0] result_o;
  logic         valid_o, rsvd_o, invalid_o;
  int           n_chk = 0, n_bad = 0;
  bit           done = 0;
  exp_t         q[$];

  sfc_mask_unit dut (.clk_i(clk), .rst_ni, .valid_i, .op_a_i, .op_b_i, .imm_i,
                     .result_o, .valid_o, .rsvd_o, .invalid_o);

  always #5 clk = ~clk;

  function automatic bit f_nan(logic [31:0] v);
    return v[30:23] == 8'hFF && v[22:0] != 0;
  endfunction
  function automatic longint f_key(logic [31:0] v);
    longint m = longint'(v[30:0]);
    return v[31] ? -m : m;
  endfunction

  function automatic exp_t model(logic [127:0] a, logic [127:0] b, logic [7:0] imm, string tag);
    exp_t e;
    bit un, eq, lt, h, qn, sn;
    un = f_nan(a[31:0]) || f_nan(b[31:0]);
    eq = !un && f_key(a[31:0]) == f_key(b[31:0]);
    lt = !un && f_key(a[31:0]) <  f_key(b[31:0]);
    case (imm[2:0])
      0: h = eq;      1: h = lt;        2: h = lt | eq;     3: h = un;
      4: h = !eq;     5: h = !lt;       6: h = !(lt | eq);  default: h = !un;
    endcase
    sn = (f_nan(a[31:0]) && !a[22]) || (f_nan(b[31:0]) && !b[22]);
    qn = un;
    e.rsvd = imm > 7;
    e.res  = {a[127:32], (h && !e.rsvd) ? 32'hFFFF_FFFF : 32'h0};
    e.inv  = !e.rsvd && (sn || (qn && imm[2:0] inside {1, 2, 5, 6}));
    e.tag  = tag;
    return e;
  endfunction

  task automatic drive(logic [31:0] a, logic [31:0] b, logic [7:0] imm, string tag);
    logic [127:0] fa = {$urandom, $urandom, $urandom, a};
    logic [127:0] fb = {$urandom, $urandom, $urandom, b};
    @(negedge clk);
    op_a_i = fa; op_b_i = fb; imm_i = imm; valid_i = 1;
    q.push_back(model(fa, fb, imm, tag));
    @(negedge clk);
    valid_i = 0;
  endtask

  always @(negedge clk) if (rst_ni && valid_o) begin
    exp_t e;
    n_chk++;
    if (q.size() == 0) begin
      n_bad++; $display("FAIL R10 unexpected valid_o act=1 exp=0");
    end else begin
      e = q.pop_front();
      if (result_o !== e.res || rsvd_o !== e.rsvd || invalid_o !== e.inv) begin
        n_bad++;
        $display("FAIL %s act=%h/%b/%b exp=%h/%b/%b", e.tag, result_o, rsvd_o, invalid_o,
                 e.res, e.rsvd, e.inv);
      end
    end
  end

  localparam logic [31:0] PZ = 32'h0, NZ = 32'h8000_0000, ONE = 32'h3F80_0000,
    TWO = 32'h4000_0000, NONE = 32'hBF80_0000, NTWO = 32'hC000_0000,
    QN = 32'h7FC0_0001, SN = 32'h7F80_0001, INF = 32'h7F80_0000,
    DN1 = 32'h0000_0001, DN2 = 32'h0000_0002;

  initial begin
    logic [31:0] pool [12] = '{PZ, NZ, ONE, TWO, NONE, NTWO, QN, SN, INF, DN1, DN2, 32'hFFC0_0000};
    repeat (3) @(negedge clk);
    n_chk++;
    if (result_o !== '0 || valid_o !== 0 || rsvd_o !== 0 || invalid_o !== 0) begin
      n_bad++; $display("FAIL R10 reset act=%h/%b exp=0/0", result_o, valid_o);
    end
    rst_ni = 1;
    for (int p = 0; p < 8; p++) begin
      drive(ONE, TWO, 8'(p), "R1 1<2");
      drive(TWO, ONE, 8'(p), "R1 2>1");
      drive(ONE, ONE, 8'(p), "R1 1==1");
      drive(QN, ONE, 8'(p), "R6 qnan");
      drive(ONE, SN, 8'(p), "R9 snan");
      drive(PZ, NZ, 8'(p), "R7 zeros");
      drive(NTWO, NONE, 8'(p), "R8 neg");
    end
    drive(TWO, ONE, 8'd1, "R2 gt via swap lt(b,a)");
    drive(TWO, TWO, 8'd2, "R2 ge via swap le(b,a)");
    drive(DN1, DN2, 8'd1, "R7 denorm lt");
    drive(DN1, PZ, 8'd0, "R7 denorm ne zero");
    drive(NONE, ONE, 8'd1, "R8 mixed sign");
    drive(INF, TWO, 8'd5, "R8 inf");
    drive(ONE, ONE, 8'd8, "R5 imm 8");
    drive(SN, QN, 8'hFF, "R5 imm ff");
    drive(ONE, TWO, 8'h41, "R5 imm 41");
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a = (i % 3 == 0) ? $urandom : pool[$urandom % 12];
      logic [31:0] b = (i % 4 == 0) ? $urandom : pool[$urandom % 12];
      drive(a, b, (i % 9 == 0) ? 8'($urandom) : 8'($urandom % 8), "R3 R4 random");
    end
    // back-to-back: R10
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      op_a_i = {96'($urandom), ONE}; op_b_i = {96'h0, TWO}; imm_i = 8'(i); valid_i = 1;
      q.push_back(model(op_a_i, op_b_i, imm_i, "R10 back-to-back"));
      @(negedge clk);
    end
    valid_i = 0;
    repeat (4) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_bad++; $display("FAIL R10 missing results act=%0d exp=0", q.size());
    end
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin @(posedge clk); cyc++; end
    if (!done) begin
      n_chk++; n_bad++; $display("FAIL R10 watchdog act=hung exp=done");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule